// File: doc/BRIEF.md
# Committed Clock Output Source Selector

This block drives one clock output from one of four free-running input clocks. Software picks the source in two steps. First it writes a 2-bit code into a staging register. Then it commits that code by moving a single update bit from 0 to 1. Until the commit, the staged code has no effect on the output. Each input clock is assumed to be running whenever it is involved in a switch.

The register side runs on a bus clock and has a one-cycle write port and a combinational read port. The switch itself crosses clock domains and is break-before-make. The old source is gated off on its own falling edge. The request for the new source then passes two flops in the new source's domain, and the new source is enabled on its falling edge. A status output reports the source that is currently driving the output. If a second commit arrives while a switch is still under way, it is held until that switch has finished, and then the latest staged code is applied.

Source codes: 0 is the internal RC oscillator (`srcClk[0]`), 1 is the system oscillator (`srcClk[1]`), 2 is the watchdog oscillator (`srcClk[2]`) and 3 is the main clock (`srcClk[3]`).

Top module: `clkout_selector`

## Requirements
- R1: After reset, the select register and the update register both read 0, `activeSel` settles to 0, and `clkOut` follows `srcClk[0]`.
- R2: A write to the select register (address 0) changes the readback at address 0 to the staged code. It changes neither `clkOut` nor `activeSel`.
- R3: A write of bit 0 = 1 to the update register (address 1), made while that bit holds 0, commits the staged code. `clkOut` then runs at the committed source's period, and `activeSel` reports that code.
- R4: A write of 1 to the update bit while it already holds 1 does not start a switch. A write of 0 to the update bit clears the bit but leaves the output unchanged.
- R5: Only bits 1:0 of the select register and bit 0 of the update register are stored. All higher bits read as 0, and writes to them are ignored.
- R6: `clkOut` never has a high or low pulse shorter than half the period of the faster of the two clocks taking part in a switch. At no time are two sources enabled at once.
- R7: A commit that arrives while a switch is still in progress is deferred. The current switch completes first, and then the latest staged code is applied.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Register-interface clock |
| rstN | input | 1 | Asynchronous active-low reset |
| wrEn | input | 1 | Write strobe, one bus cycle per write |
| wrAddr | input | 1 | Write address: 0 selects the select register, 1 the update register |
| wrData | input | 32 | Write data |
| rdAddr | input | 1 | Read address, same map as `wrAddr` |
| rdData | output | 32 | Read data (combinational) |
| srcClk | input | 4 | Candidate source clocks, indexed by source code |
| clkOut | output | 1 | Selected output clock |
| activeSel | output | 2 | Code of the source currently driving `clkOut` |

## Verification
The hardest case to reach is a commit that lands while a switch is still in flight. The stimulus first commits a move to the slowest source, which has a 22 ns period, so that switch takes many bus cycles. It then restages a different code and writes the update bit 0 and then 1 within a few bus cycles. This forces the deferred-commit path, and the bench checks that the final source is the restaged one. A monitor times every high and low pulse on `clkOut` through all the switches, so that any runt pulse left by a wrong gating edge is caught.

// File: rtl/clkout_sel_pkg.sv
`timescale 1ns/1ps
package clkout_sel_pkg;
  localparam int SRC_COUNT = 4;
  localparam int SEL_W     = $clog2(SRC_COUNT);

  // Control -> datapath strobes.
  typedef struct packed {
    logic [SRC_COUNT-1:0] reqOneHot;
  } ctrlStrobes_t;

  // Datapath -> control status, already in the bus domain.
  typedef struct packed {
    logic [SRC_COUNT-1:0] enSynced;
  } dpStatus_t;
endpackage

// File: rtl/clkout_sel_ctrl.sv
`timescale 1ns/1ps
module clkout_sel_ctrl
  import clkout_sel_pkg::*;
#(
  parameter int DATAW = 32
) (
  input  logic             clk,
  input  logic             rstN,
  input  logic             wrEn,
  input  logic             wrAddr,
  input  logic [DATAW-1:0] wrData,
  input  logic             rdAddr,
  output logic [DATAW-1:0] rdData,
  input  dpStatus_t        dpStatus,
  output ctrlStrobes_t     strobes,
  output logic [SEL_W-1:0] activeSel
);
  localparam logic ADDR_SEL = 1'b0;
  localparam logic ADDR_UEN = 1'b1;

  logic [SEL_W-1:0]     stagedSel;
  logic                 uenBit;
  logic                 commitPulse;
  logic                 pending;
  logic [SEL_W-1:0]     targetSel;
  logic                 pastValid;
  logic [SRC_COUNT-1:0] targetOneHot;
  logic                 busy;
  logic [SEL_W-1:0]     enIndex;
  logic                 enIsOne;
  logic                 writeSel;
  logic                 writeUen;
  logic                 unusedWrBits;

  assign writeSel     = wrEn && (wrAddr == ADDR_SEL);
  assign writeUen     = wrEn && (wrAddr == ADDR_UEN);
  assign unusedWrBits = ^wrData[DATAW-1:SEL_W];

  assign targetOneHot = SRC_COUNT'(1) << targetSel;
  assign busy         = (dpStatus.enSynced != targetOneHot);

  always_comb begin
    enIndex = '0;
    for (int i = 0; i < SRC_COUNT; i++) begin
      if (dpStatus.enSynced[i]) enIndex = i[SEL_W-1:0];
    end
    enIsOne = ($countones(dpStatus.enSynced) == 1);
  end

  // Register file: staging select and update bit.
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      stagedSel   <= '0;
      uenBit      <= 1'b0;
      commitPulse <= 1'b0;
      pastValid   <= 1'b0;
    end else begin
      pastValid   <= 1'b1;
      commitPulse <= writeUen && wrData[0] && !uenBit;
      if (writeSel) stagedSel <= wrData[SEL_W-1:0];
      if (writeUen) uenBit    <= wrData[0];
    end
  end

  // Commit sequencing: apply now when idle, else defer until the switch ends.
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      targetSel <= '0;
      pending   <= 1'b0;
    end else if ((commitPulse || pending) && !busy) begin
      targetSel <= stagedSel;
      pending   <= 1'b0;
    end else if (commitPulse) begin
      pending   <= 1'b1;
    end
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) activeSel <= '0;
    else if (enIsOne) activeSel <= enIndex;
  end

  assign strobes.reqOneHot = targetOneHot;

  always_comb begin
    rdData = '0;
    if (rdAddr == ADDR_UEN) rdData[0] = uenBit;
    else                    rdData[SEL_W-1:0] = stagedSel;
  end

  AST_TARGET_NEEDS_COMMIT: assert property (@(posedge clk) disable iff (!rstN)
    (pastValid && (targetSel != $past(targetSel))) |-> ($past(commitPulse) || $past(pending))) // R3
    else $error("target changed without a commit");

  AST_NO_REPEAT_COMMIT: assert property (@(posedge clk) disable iff (!rstN)
    (writeUen && uenBit) |=> !commitPulse) // R4
    else $error("commit from a write while the bit was already 1");

  AST_SELECT_ONLY_STAGES: assert property (@(posedge clk) disable iff (!rstN)
    (writeSel && !commitPulse && !pending) |=> $stable(targetSel)) // R2
    else $error("select write moved the target");

  AST_ONE_ENABLE_MAX: assert property (@(posedge clk) disable iff (!rstN)
    $onehot0(dpStatus.enSynced)) // R6
    else $error("two sources enabled together");
endmodule

// File: rtl/clkout_sel_datapath.sv
`timescale 1ns/1ps
module clkout_sel_datapath
  import clkout_sel_pkg::*;
#(
  parameter int SYNC_STAGES = 2
) (
  input  logic                 clk,
  input  logic                 rstN,
  input  logic [SRC_COUNT-1:0] srcClk,
  input  ctrlStrobes_t         strobes,
  output dpStatus_t            dpStatus,
  output logic                 clkOut
);
  logic [SRC_COUNT-1:0] enNeg;
  logic [SRC_COUNT-1:0] gated;

  for (genvar i = 0; i < SRC_COUNT; i++) begin : g_src
    logic [SYNC_STAGES-1:0] syncChain;
    logic                   enLocal;
    logic                   othersOff;
    logic                   reqRaw;

    // Break before make: request only after every other source is gated off.
    assign othersOff = ~|(enNeg & ~(SRC_COUNT'(1) << i));
    assign reqRaw    = strobes.reqOneHot[i] & othersOff;

    always_ff @(posedge srcClk[i] or negedge rstN) begin
      if (!rstN) syncChain <= '0;
      else       syncChain <= {syncChain[SYNC_STAGES-2:0], reqRaw};
    end

    // Enable changes only while this clock is low, so the AND cannot slice a pulse.
    always_ff @(negedge srcClk[i] or negedge rstN) begin
      if (!rstN) enLocal <= 1'b0;
      else       enLocal <= syncChain[SYNC_STAGES-1];
    end

    assign enNeg[i] = enLocal;
    assign gated[i] = srcClk[i] & enLocal;
  end

  assign clkOut = |gated;

  // Enables back into the bus domain.
  logic [SRC_COUNT-1:0] busSync1;
  logic [SRC_COUNT-1:0] busSync2;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      busSync1 <= '0;
      busSync2 <= '0;
    end else begin
      busSync1 <= enNeg;
      busSync2 <= busSync1;
    end
  end

  assign dpStatus.enSynced = busSync2;
endmodule

// File: rtl/clkout_selector.sv
`timescale 1ns/1ps
module clkout_selector
  import clkout_sel_pkg::*;
#(
  parameter int DATAW = 32
) (
  input  logic                 clk,
  input  logic                 rstN,
  input  logic                 wrEn,
  input  logic                 wrAddr,
  input  logic [DATAW-1:0]     wrData,
  input  logic                 rdAddr,
  output logic [DATAW-1:0]     rdData,
  input  logic [SRC_COUNT-1:0] srcClk,
  output logic                 clkOut,
  output logic [SEL_W-1:0]     activeSel
);
  ctrlStrobes_t strobes;
  dpStatus_t    dpStatus;

  clkout_sel_ctrl #(.DATAW(DATAW)) u_ctrl (
    .clk       (clk),
    .rstN      (rstN),
    .wrEn      (wrEn),
    .wrAddr    (wrAddr),
    .wrData    (wrData),
    .rdAddr    (rdAddr),
    .rdData    (rdData),
    .dpStatus  (dpStatus),
    .strobes   (strobes),
    .activeSel (activeSel)
  );

  clkout_sel_datapath #(.SYNC_STAGES(2)) u_dp (
    .clk      (clk),
    .rstN     (rstN),
    .srcClk   (srcClk),
    .strobes  (strobes),
    .dpStatus (dpStatus),
    .clkOut   (clkOut)
  );
endmodule

// File: tb/tb_clkout_selector.sv
`timescale 1ns/1ps
module tb_clkout_selector;
  logic        clk = 1'b0;
  logic        rstN = 1'b0;
  logic        wrEn = 1'b0;
  logic        wrAddr = 1'b0;
  logic [31:0] wrData = '0;
  logic        rdAddr = 1'b0;
  logic [31:0] rdData;
  logic [3:0]  srcClk = '0;
  logic        clkOut;
  logic [1:0]  activeSel;

  int  checks = 0;
  int  errors = 0;
  int  runts  = 0;
  bit  finished = 1'b0;
  real periods[4] = '{10.0, 14.0, 22.0, 6.0};
  real lastEdge = -1.0;

  clkout_selector dut (
    .clk(clk), .rstN(rstN), .wrEn(wrEn), .wrAddr(wrAddr), .wrData(wrData),
    .rdAddr(rdAddr), .rdData(rdData), .srcClk(srcClk), .clkOut(clkOut),
    .activeSel(activeSel)
  );

  always #2 clk = ~clk;
  initial begin #1.3; forever #5  srcClk[0] = ~srcClk[0]; end
  initial begin #0.7; forever #7  srcClk[1] = ~srcClk[1]; end
  initial begin #2.1; forever #11 srcClk[2] = ~srcClk[2]; end
  initial begin #0.4; forever #3  srcClk[3] = ~srcClk[3]; end

  // Pulse-width monitor for R6: shortest half period among the sources is 3 ns.
  always @(clkOut) begin
    if (rstN) begin
      if (lastEdge >= 0.0 && ($realtime - lastEdge) < 2.9) runts++;
      lastEdge = $realtime;
    end
  end

  task automatic check(input bit ok, input string req, input string what,
                       input longint actual, input longint expected);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s %s: actual=%0d expected=%0d", req, what, actual, expected);
    end
  endtask

  task automatic regWrite(input logic addr, input logic [31:0] data);
    @(negedge clk);
    wrEn = 1'b1; wrAddr = addr; wrData = data;
    @(negedge clk);
    wrEn = 1'b0;
  endtask

  task automatic regRead(input logic addr, output logic [31:0] data);
    @(negedge clk);
    rdAddr = addr;
    #1;
    data = rdData;
  endtask

  task automatic checkPeriod(input int src, input string req);
    real t0, t1, diff;
    @(posedge clkOut); t0 = $realtime;
    @(posedge clkOut); t1 = $realtime;
    diff = (t1 - t0) - periods[src];
    if (diff < 0.0) diff = -diff;
    check(diff < 0.2, req, "clkOut period x10 ns",
          longint'((t1 - t0) * 10.0), longint'(periods[src] * 10.0));
  endtask

  task automatic settle();
    #1000;
    @(negedge clk);
  endtask

  task automatic t_reset();
    logic [31:0] d;
    settle();
    regRead(1'b0, d); check(d == 32'd0, "R1", "select after reset", d, 0);
    regRead(1'b1, d); check(d == 32'd0, "R1", "update after reset", d, 0);
    check(activeSel == 2'd0, "R1", "activeSel after reset", activeSel, 0);
    checkPeriod(0, "R1");
  endtask

  task automatic t_stageOnly();
    logic [31:0] d;
    regWrite(1'b0, 32'd2);
    regRead(1'b0, d); check(d == 32'd2, "R2", "staged readback", d, 2);
    settle();
    check(activeSel == 2'd0, "R2", "activeSel after staging", activeSel, 0);
    checkPeriod(0, "R2");
  endtask

  task automatic t_commit();
    logic [31:0] d;
    regWrite(1'b1, 32'd1);
    settle();
    check(activeSel == 2'd2, "R3", "activeSel after commit", activeSel, 2);
    regRead(1'b1, d); check(d == 32'd1, "R3", "update bit readback", d, 1);
    checkPeriod(2, "R3");
  endtask

  task automatic t_repeatAndZero();
    logic [31:0] d;
    regWrite(1'b0, 32'd1);
    regWrite(1'b1, 32'd1);
    settle();
    check(activeSel == 2'd2, "R4", "write 1 over 1 ignored", activeSel, 2);
    regWrite(1'b1, 32'd0);
    settle();
    check(activeSel == 2'd2, "R4", "write 0 no switch", activeSel, 2);
    regRead(1'b1, d); check(d == 32'd0, "R4", "update bit cleared", d, 0);
    checkPeriod(2, "R4");
    regWrite(1'b1, 32'd1);
    settle();
    check(activeSel == 2'd1, "R3", "second commit", activeSel, 1);
    checkPeriod(1, "R3");
    regWrite(1'b1, 32'd0);
  endtask

  task automatic t_reserved();
    logic [31:0] d;
    regWrite(1'b0, 32'hFFFF_FFFF);
    regRead(1'b0, d); check(d == 32'd3, "R5", "select upper bits", d, 3);
    regWrite(1'b1, 32'hFFFF_FFFE);
    regRead(1'b1, d); check(d == 32'd0, "R5", "update upper bits", d, 0);
    settle();
    check(activeSel == 2'd1, "R5", "reserved write no switch", activeSel, 1);
  endtask

  task automatic t_pending();
    logic [31:0] d;
    regWrite(1'b0, 32'd2);
    regWrite(1'b1, 32'd1);   // switch toward the slow source starts
    regWrite(1'b0, 32'd3);
    regWrite(1'b1, 32'd0);
    regWrite(1'b1, 32'd1);   // second commit while the first is in flight
    settle();
    check(activeSel == 2'd3, "R7", "latest staged applied", activeSel, 3);
    regRead(1'b0, d); check(d == 32'd3, "R7", "staged readback", d, 3);
    checkPeriod(3, "R7");
  endtask

  task automatic t_glitch();
    check(runts == 0, "R6", "runt pulses on clkOut", runts, 0);
  endtask

  initial begin
    #50;
    rstN = 1'b1;
    t_reset();
    t_stageOnly();
    t_commit();
    t_repeatAndZero();
    t_reserved();
    t_pending();
    t_glitch();
    finished = 1'b1;
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    #200000;
    if (!finished) begin
      checks++;
      errors++;
      $display("FAIL watchdog: actual=%0d expected=%0d", 0, 1);
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end
endmodule